// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a clocked model of a synchronous burst SRAM. Every rising clock edge samples three chip enables, two address strobes, an advance input and the write controls. From these the block chooses one cycle type:

- **deselect**
- **begin read or write** at the external address
- **continue** the burst at the next address
- **suspend** the burst at the current address

A small behavioural array holds the data. Writes merge byte lanes into it, and reads return through a registered output stage.

The two strobes follow different rules:

- **Processor strobe** (`cpu_strb_n`). It always starts a read, and it is ignored while the first chip enable is high.
- **Controller strobe** (`ctl_strb_n`). It can start a write directly.

Once a burst has started, cycles without a strobe step the two-bit burst counter (linear order, wrapping within a group of four) or hold it.

Output drive is split into a data output and a drive flag. The surrounding logic builds the tri-state bus from these. The drive flag follows the asynchronous output enable, and it is masked during writes, deselected cycles and sleep.

Top module: `burst_sram_model`

## Requirements
- R1: The device counts as selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A strobe cycle that starts no access while unselected deselects the device: `dq_oe` is 0 from the next edge on. Until a new strobe starts an access, cycles without a strobe write nothing and keep `dq_oe` at 0.
- R2: A `cpu_strb_n`=0 cycle with the device selected begins a read at `addr`, whatever `gwr_n`, `bwr_n` and `lane_en_n` are doing. It never writes.
- R3: While `sel_a_n`=1, `cpu_strb_n` is ignored. A `ctl_strb_n`=0 cycle in that state deselects the device. With both strobes otherwise inactive, an active burst simply continues.
- R4: A selected `ctl_strb_n`=0 cycle with a write request writes `dq_i` to `addr` in that cycle. Without a write request it begins a read at `addr`.
- R5: Write request and lane mask:
  - `gwr_n`=0 writes all four byte lanes.
  - `gwr_n`=1 and `bwr_n`=0 write each lane i whose `lane_en_n[i]`=0. Lane i is `dq_i[8i+7:8i]`.
  - Any other combination, including `bwr_n`=1, is a read.
- R6: In an active burst, a cycle with no strobe and `adv_n`=0 uses the next address. That address increments the two low address bits modulo 4 and keeps the upper bits.
- R7: In an active burst, a cycle with no strobe and `adv_n`=1 reuses the current address. This is how a write on the clock after a processor-strobe read reaches that read's address.
- R8: Read data appears on `dq_o` one edge after its address is used. `dq_oe` equals NOT `oe_n` while that read result is held, and it follows `oe_n` without waiting for a clock.
- R9: After an edge that performs a write, `dq_oe` is 0 whatever `oe_n` is.
- R10: While `sleep`=1:
  - no cycle starts and no write happens;
  - the burst address and state are held;
  - `dq_oe` is 0.

  After `sleep` returns to 0, the burst continues from the held address.
- R11: While `rst_n`=0, and after it, no burst is active and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_a_n | input | 1 | First chip enable, active low; also gates the processor strobe |
| sel_b | input | 1 | Second chip enable, active high |
| sel_c_n | input | 1 | Third chip enable, active low |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte write enable, active low |
| lane_en_n | input | LANES (4) | Per-lane write enables, active low |
| addr | input | ADDR_W (8) | External address |
| dq_i | input | LANES*LANE_W (32) | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Freezes all activity when high |
| dq_o | output | LANES*LANE_W (32) | Registered read data |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The hardest case to reach is the hand-over between strobe rules: a processor strobe issued while the first chip enable is high, in the middle of an active burst. It must fall through and continue the burst, whereas the same cycle with the controller strobe must deselect. The bench reaches this by opening a processor-strobe read, then driving the processor strobe with the first enable high and the controller strobe inactive. It then repeats that cycle with the controller strobe low. Sleep is entered inside a running burst, together with a write attempt, and the later reads show that both the counter and the array stayed untouched.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } sbm_op_e;

   typedef enum logic [1:0] {
      AS_EXT  = 2'd0,
      AS_CUR  = 2'd1,
      AS_NEXT = 2'd2
   } sbm_asrc_e;
endpackage

// File: rtl/sbm_cycle_dec.sv
module sbm_cycle_dec
   import sbm_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             sel_a_n,
   input  logic             sel_b,
   input  logic             sel_c_n,
   input  logic             cpu_strb_n,
   input  logic             ctl_strb_n,
   input  logic             adv_n,
   input  logic             gwr_n,
   input  logic             bwr_n,
   input  logic [LANES-1:0] lane_en_n,
   input  logic             sleep,
   input  logic             active,
   output sbm_op_e          op,
   output sbm_asrc_e        asrc,
   output logic             start,
   output logic             stop,
   output logic [LANES-1:0] lane_we
);
   logic             selected;
   logic [LANES-1:0] req_mask;

   assign selected = !sel_a_n && sel_b && !sel_c_n;

   always_comb begin
      if (!gwr_n)      req_mask = '1;
      else if (!bwr_n) req_mask = ~lane_en_n;
      else             req_mask = '0;
   end

   always_comb begin
      op    = OP_NONE;
      asrc  = AS_CUR;
      start = 1'b0;
      stop  = 1'b0;
      if (!sleep) begin
         if (!cpu_strb_n && !sel_a_n) begin
            if (selected) begin
               op    = OP_READ;
               asrc  = AS_EXT;
               start = 1'b1;
            end else begin
               stop = 1'b1;
            end
         end else if (!ctl_strb_n) begin
            if (selected) begin
               op    = (|req_mask) ? OP_WRITE : OP_READ;
               asrc  = AS_EXT;
               start = 1'b1;
            end else begin
               stop = 1'b1;
            end
         end else if (active) begin
            op   = (|req_mask) ? OP_WRITE : OP_READ;
            asrc = adv_n ? AS_CUR : AS_NEXT;
         end
      end
   end

   assign lane_we = (op == OP_WRITE) ? req_mask : '0;
endmodule

// File: rtl/sbm_burst_addr.sv
module sbm_burst_addr
   import sbm_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sbm_op_e           op,
   input  sbm_asrc_e         asrc,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [BURST_W-1:0] cnt_q
);
   localparam int HI_W = ADDR_W - BURST_W;

   if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
      $error("sbm_burst_addr: BURST_W must lie in 1..ADDR_W-1");
   end

   logic [HI_W-1:0]    hi_q;
   logic [BURST_W-1:0] cnt_nxt;

   assign cnt_nxt = cnt_q + 1'b1;

   always_comb begin
      case (asrc)
         AS_EXT:  eff_addr = addr_in;
         AS_NEXT: eff_addr = {hi_q, cnt_nxt};
         default: eff_addr = {hi_q, cnt_q};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         cnt_q <= '0;
      end else if (op != OP_NONE) begin
         {hi_q, cnt_q} <= eff_addr;
      end
   end

   p_step_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_NONE && asrc == AS_NEXT) |=>
         (cnt_q == $past(cnt_q) + 1'b1) && $stable(hi_q));

   p_suspend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_NONE && asrc == AS_CUR) |=> $stable(cnt_q) && $stable(hi_q));
endmodule

// File: rtl/sbm_mem.sv
module sbm_mem #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_en,
   input  logic [LANES-1:0]        lane_we,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata_q
);
   localparam int DEPTH = 1 << ADDR_W;

   if (DEPTH * LANES > 4096) begin : g_bad_size
      $error("sbm_mem: array too large for a behavioural model");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] arr [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[i]) arr[addr] <= wdata[i*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rdata_q[i*LANE_W +: LANE_W] <= '0;
         else if (rd_en) rdata_q[i*LANE_W +: LANE_W] <= arr[addr];
      end
   end

   p_no_rw_clash_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (lane_we == '0));
endmodule

// File: rtl/burst_sram_model.sv
module burst_sram_model
   import sbm_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int BURST_W = 2,
   parameter int LANES   = 4,
   parameter int LANE_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    cpu_strb_n,
   input  logic                    ctl_strb_n,
   input  logic                    adv_n,
   input  logic                    gwr_n,
   input  logic                    bwr_n,
   input  logic [LANES-1:0]        lane_en_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] dq_i,
   input  logic                    oe_n,
   input  logic                    sleep,
   output logic [LANES*LANE_W-1:0] dq_o,
   output logic                    dq_oe
);
   localparam int DATA_W = LANES * LANE_W;

   if (LANE_W < 1 || LANES < 1) begin : g_bad_lanes
      $error("burst_sram_model: LANES and LANE_W must be positive");
   end

   sbm_op_e            op;
   sbm_asrc_e          asrc;
   logic               start, stop, active_q, rd_valid_q;
   logic [LANES-1:0]   lane_we;
   logic [ADDR_W-1:0]  eff_addr;
   logic [BURST_W-1:0] cnt_q;
   logic [DATA_W-1:0]  rdata_q;

   sbm_cycle_dec #(.LANES(LANES)) dec_i (
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .adv_n(adv_n),
      .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_en_n(lane_en_n),
      .sleep(sleep), .active(active_q),
      .op(op), .asrc(asrc), .start(start), .stop(stop), .lane_we(lane_we)
   );

   sbm_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) adr_i (
      .clk(clk), .rst_n(rst_n), .op(op), .asrc(asrc), .addr_in(addr),
      .eff_addr(eff_addr), .cnt_q(cnt_q)
   );

   sbm_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) mem_i (
      .clk(clk), .rst_n(rst_n), .rd_en(op == OP_READ), .lane_we(lane_we),
      .addr(eff_addr), .wdata(dq_i), .rdata_q(rdata_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         rd_valid_q <= 1'b0;
      end else if (!sleep) begin
         if (start)     active_q <= 1'b1;
         else if (stop) active_q <= 1'b0;
         rd_valid_q <= (op == OP_READ);
      end
   end

   assign dq_o  = rdata_q;
   assign dq_oe = rd_valid_q && !oe_n && !sleep;

   p_unsel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !ctl_strb_n && (cpu_strb_n || sel_a_n) && !(!sel_a_n && sel_b && !sel_c_n))
         |=> !rd_valid_q && !active_q);

   p_cpu_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !cpu_strb_n && !sel_a_n && sel_b && !sel_c_n) |=> rd_valid_q);

   p_ce1_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && sel_a_n && !cpu_strb_n && ctl_strb_n && !active_q) |=> !rd_valid_q);

   p_write_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|lane_we) |=> !dq_oe);

   p_sleep_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> $stable(cnt_q) && $stable(active_q) && $stable(rd_valid_q));

   p_sleep_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (lane_we == '0));

   always_comb begin
      if (!rst_n) p_reset_quiet_r11: assert (!dq_oe);
   end
endmodule

// File: tb/burst_sram_model_tb.sv
`timescale 1ns/1ps
module burst_sram_model_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
   logic        cpu_strb_n = 1'b1, ctl_strb_n = 1'b1, adv_n = 1'b1;
   logic        gwr_n = 1'b1, bwr_n = 1'b1;
   logic [3:0]  lane_en_n = 4'hF;
   logic [7:0]  addr = '0;
   logic [31:0] dq_i = '0;
   logic        oe_n = 1'b0, sleep = 1'b0;
   logic [31:0] dq_o;
   logic        dq_oe;

   int checks_n = 0;
   int fails_n  = 0;

   always #10 clk = ~clk;

   burst_sram_model dut_i (
      .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .adv_n(adv_n),
      .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_en_n(lane_en_n), .addr(addr),
      .dq_i(dq_i), .oe_n(oe_n), .sleep(sleep), .dq_o(dq_o), .dq_oe(dq_oe)
   );

   typedef struct {
      logic        oe;
      logic [31:0] data;
      string       tag;
   } exp_t;
   exp_t sbq[$];

   // reference state built from the requirements
   logic [31:0] mem_m [256];
   logic        act_m = 1'b0, rd_m = 1'b0;
   logic [5:0]  hi_m = '0;
   logic [1:0]  cnt_m = '0;
   logic [31:0] rdat_m = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks_n++;
      if (!ok) begin
         fails_n++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per clock edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks_n++;
            if (dq_oe !== e.oe || (e.oe && dq_o !== e.data)) begin
               fails_n++;
               $display("FAIL %s: actual oe=%b data=%h expected oe=%b data=%h",
                        e.tag, dq_oe, dq_o, e.oe, e.data);
            end
         end
      end
   end

   // driver: applies one cycle at a negedge and queues the expected result
   task automatic step(input logic c1n, c2, c3n, psn, csn, advn, gwn, bwen,
                       input logic [3:0] ben, input logic [7:0] a, input logic [31:0] d,
                       input logic slp, oen, input string tag);
      logic       sel, have;
      logic [3:0] msk;
      logic [7:0] ea;
      exp_t       e;
      sel_a_n = c1n; sel_b = c2; sel_c_n = c3n; cpu_strb_n = psn; ctl_strb_n = csn;
      adv_n = advn; gwr_n = gwn; bwr_n = bwen; lane_en_n = ben; addr = a; dq_i = d;
      sleep = slp; oe_n = oen;
      if (!slp) begin
         sel  = !c1n && c2 && !c3n;
         msk  = !gwn ? 4'hF : (!bwen ? ~ben : 4'h0);
         have = 1'b0;
         ea   = a;
         if (!psn && !c1n) begin
            if (sel) begin act_m = 1'b1; have = 1'b1; msk = 4'h0; end
            else act_m = 1'b0;
         end else if (!csn) begin
            if (sel) begin act_m = 1'b1; have = 1'b1; end
            else act_m = 1'b0;
         end else if (act_m) begin
            if (!advn) cnt_m = cnt_m + 2'd1;
            ea = {hi_m, cnt_m};
            have = 1'b1;
         end
         if (have) begin
            hi_m = ea[7:2]; cnt_m = ea[1:0];
            if (msk != 4'h0) begin
               for (int i = 0; i < 4; i++)
                  if (msk[i]) mem_m[ea][8*i +: 8] = d[8*i +: 8];
               rd_m = 1'b0;
            end else begin
               rd_m = 1'b1; rdat_m = mem_m[ea];
            end
         end else begin
            rd_m = 1'b0;
         end
      end
      e.oe = rd_m && !oen && !slp;
      e.data = rdat_m;
      e.tag = tag;
      sbq.push_back(e);
      @(negedge clk);
   endtask

   task automatic cs_wr(input logic [7:0] a, input logic [31:0] d, input string tag);
      step(0, 1, 0, 1, 0, 1, 0, 1, 4'hF, a, d, 0, 1, tag);
   endtask
   task automatic cs_bytes(input logic [7:0] a, input logic [31:0] d, input logic [3:0] ben, input string tag);
      step(0, 1, 0, 1, 0, 1, 1, 0, ben, a, d, 0, 0, tag);
   endtask
   // processor strobe with write controls asserted: must still read (R2)
   task automatic ps_rd(input logic [7:0] a, input string tag);
      step(0, 1, 0, 0, 1, 1, 0, 0, 4'h0, a, 32'hDEAD_BEEF, 0, 0, tag);
   endtask
   // no strobe, enables unselected on purpose (don't care in a burst)
   task automatic go(input logic advn, input logic wr, input logic [31:0] d, input string tag);
      step(1, 0, 1, 1, 1, advn, !wr, 1, 4'hF, 8'hEE, d, 0, 0, tag);
   endtask

   function automatic logic [31:0] pat(input logic [7:0] a);
      return {a, ~a, a ^ 8'h5A, 8'hC3};
   endfunction

   initial begin
      #(200000 * 20);
      fails_n++;
      checks_n++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks_n - fails_n, checks_n);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(dq_oe === 1'b0, "R11 reset drive", {31'b0, dq_oe}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dq_oe === 1'b0, "R11 after reset", {31'b0, dq_oe}, 32'h0);

      // R4 controller-strobe write, R6 burst wrap, R9 writes mask oe
      cs_wr(8'h12, pat(8'h12), "R4 ctl write");
      go(0, 1, pat(8'h13), "R9 write masks oe");
      go(0, 1, pat(8'h10), "R6 wrap write");
      go(0, 1, pat(8'h11), "R6 write");

      // R2 processor read ignores write controls; R6 wrap; R7 suspend
      ps_rd(8'h12, "R2 cpu read");
      go(0, 0, '0, "R6 next");
      go(0, 0, '0, "R6 wrap to 0x10");
      go(1, 0, '0, "R7 suspend");
      go(0, 0, '0, "R6 after suspend");

      // R5 lane merge
      cs_wr(8'h20, 32'h1122_3344, "R5 full write");
      cs_bytes(8'h20, 32'hAABB_CCDD, 4'b1010, "R5 lanes 0,2");
      cs_bytes(8'h20, 32'h0, 4'hF, "R5 no lane is read");
      step(0, 1, 0, 1, 0, 1, 1, 1, 4'h0, 8'h20, 32'h0, 0, 0, "R5 bwr high reads");

      // R7 write on the clock after a processor read
      ps_rd(8'h12, "R7 read before write");
      go(1, 1, 32'hCAFE_0012, "R7 write current");
      ps_rd(8'h12, "R7 readback");

      // R8 asynchronous output enable
      oe_n = 1'b1; #1;
      chk(dq_oe === 1'b0, "R8 oe high", {31'b0, dq_oe}, 32'h0);
      oe_n = 1'b0; #1;
      chk(dq_oe === 1'b1 && dq_o === 32'hCAFE_0012, "R8 oe low", dq_o, 32'hCAFE_0012);

      // R1 deselect
      step(0, 0, 0, 1, 0, 1, 1, 1, 4'hF, 8'h13, '0, 0, 0, "R1 sel_b low");
      go(0, 1, 32'hBAD0_BAD0, "R1 stays off");
      ps_rd(8'h13, "R1 no stray write");
      step(0, 1, 1, 0, 1, 1, 1, 1, 4'hF, 8'h13, '0, 0, 0, "R1 sel_c high");

      // R3 processor strobe ignored while sel_a_n high
      ps_rd(8'h10, "R3 setup");
      step(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 8'h20, '0, 0, 0, "R3 burst continues");
      step(1, 1, 0, 0, 0, 0, 1, 1, 4'hF, 8'h20, '0, 0, 0, "R3 ctl deselects");
      go(0, 0, '0, "R3 still off");

      // R10 sleep
      ps_rd(8'h10, "R10 setup");
      step(0, 1, 0, 1, 0, 1, 0, 1, 4'hF, 8'h13, 32'hBAD1_BAD1, 1, 0, "R10 sleep write");
      step(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, 8'hEE, '0, 1, 0, "R10 sleep advance");
      go(0, 0, '0, "R10 resume");
      ps_rd(8'h13, "R10 array untouched");
      go(1, 0, '0, "R10 final");

      @(negedge clk);
      $display("%0d/%0d checks passed", checks_n - fails_n, checks_n);
      $finish;
   end
endmodule